// File: doc/BRIEF.md
# UART Fractional Baud Tick Generator

This block derives the two timing enables a UART needs from the system clock. The first is a sample tick at thirteen times the bit rate. The second is a bit tick that marks each bit boundary. The divisor is a two-stage chain. A small prescaler of 1 to 16 brings the system clock down to a working rate, nominally around 12 MHz. A 10-bit baud divisor then sets how many prescaled clocks make up one sample period. The bit rate is `clk / (pre+1) / 13 / (div+1)`, so the usable range spans roughly 900 to 921600 baud.

Software loads both fields with one configuration word write. The new setting does not act at once. It is held pending and takes over at the next bit boundary, so no bit is ever shortened or stretched. A busy flag stays high while a setting is pending, and software polls it before writing again. Whenever a setting is taken up, all internal counters restart from zero.

Top module: `baud_tick_gen`

## Requirements
- R1: In the configuration word, bits [9:0] hold the baud divisor field `div` and bits [19:16] hold the prescaler field `pre`. All other bits have no effect on the tick timing.
- R2: `sample_tick` pulses once every `(pre+1)*(div+1)` clock cycles, and each pulse is one cycle wide.
- R3: `bit_tick` is high only together with `sample_tick`, on every 13th sample tick, so bit ticks are `13*(pre+1)*(div+1)` cycles apart.
- R4: After reset both fields are zero and `busy` is low. `sample_tick` is high in every cycle, and the first `bit_tick` comes in the 13th cycle after reset is released.
- R5: A write in a cycle without `bit_tick` raises `busy` in the next cycle. `busy` stays high until a `bit_tick` cycle and falls in the cycle after it.
- R6: A write made in the middle of a bit leaves that bit at its old length. The bit tick that ends it arrives at the same cycle it would have arrived without the write.
- R7: A write made in a cycle where `bit_tick` is high takes effect at that boundary, and `busy` stays low.
- R8: A second write while `busy` is high replaces the pending setting, and the last written value is the one taken up.
- R9: After a setting is taken up, the counters restart from zero. The first `sample_tick` then comes `(pre+1)*(div+1)` cycles after the boundary, and the first `bit_tick` comes `13*(pre+1)*(div+1)` cycles after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 32 | Configuration word: `div` in [9:0], `pre` in [19:16] |
| busy | output | 1 | High while a written setting waits for a bit boundary |
| sample_tick | output | 1 | Oversampling enable, 13 per bit |
| bit_tick | output | 1 | Bit boundary enable |

## Verification
Two events can land in the same cycle: a configuration write, and the bit boundary at which pending settings are applied. The bench provokes this by waiting for a cycle in which `bit_tick` is high and raising `cfg_we` in that same cycle. It then checks that `busy` never rises and that the next bit tick comes a full new-rate period later. The opposite case is also covered: a write placed mid-bit must leave the running bit's end cycle unchanged and hold `busy` until that boundary.

// File: rtl/btg_pkg.sv
package btg_pkg;
  localparam int OVS_RATIO = 13;
  localparam int OVS_W     = $clog2(OVS_RATIO);
  localparam int PRE_W_DEF = 4;
  localparam int DIV_W_DEF = 10;
  localparam int PRE_LSB_DEF = 16;
  localparam int DIV_LSB_DEF = 0;
endpackage

// File: rtl/btg_stage.sv
// Wrapping up-counter: counts advance pulses, wraps after reaching limit.
module btg_stage #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         adv,
  input  logic [W-1:0] limit,
  output logic         wrap
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         at_lim;

  assign at_lim = (cnt_q == limit);
  assign wrap   = adv & at_lim;

  always_comb begin
    cnt_d = cnt_q;
    if (restart)    cnt_d = '0;
    else if (adv)   cnt_d = at_lim ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/btg_ctrl.sv
// Holds active and pending divisor settings; applies at bit boundaries.
module btg_ctrl #(
  parameter int PRE_W = 4,
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [PRE_W-1:0] new_pre,
  input  logic [DIV_W-1:0] new_div,
  input  logic             bit_tick,
  output logic [PRE_W-1:0] act_pre,
  output logic [DIV_W-1:0] act_div,
  output logic             busy,
  output logic             apply
);
  logic [PRE_W-1:0] pre_q, pre_d, pnd_pre_q, pnd_pre_d;
  logic [DIV_W-1:0] div_q, div_d, pnd_div_q, pnd_div_d;
  logic             busy_q, busy_d;

  assign apply   = bit_tick & (cfg_we | busy_q);
  assign act_pre = pre_q;
  assign act_div = div_q;
  assign busy    = busy_q;

  always_comb begin
    pnd_pre_d = pnd_pre_q;
    pnd_div_d = pnd_div_q;
    pre_d     = pre_q;
    div_d     = div_q;
    busy_d    = busy_q;
    if (cfg_we) begin
      pnd_pre_d = new_pre;
      pnd_div_d = new_div;
      busy_d    = 1'b1;
    end
    if (apply) begin
      pre_d  = cfg_we ? new_pre : pnd_pre_q;
      div_d  = cfg_we ? new_div : pnd_div_q;
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q     <= '0;
      div_q     <= '0;
      pnd_pre_q <= '0;
      pnd_div_q <= '0;
      busy_q    <= 1'b0;
    end else begin
      pre_q     <= pre_d;
      div_q     <= div_d;
      pnd_pre_q <= pnd_pre_d;
      pnd_div_q <= pnd_div_d;
      busy_q    <= busy_d;
    end
  end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import btg_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int PRE_W   = PRE_W_DEF,
  parameter int DIV_W   = DIV_W_DEF,
  parameter int PRE_LSB = PRE_LSB_DEF,
  parameter int DIV_LSB = DIV_LSB_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic              busy,
  output logic              sample_tick,
  output logic              bit_tick
);
  localparam logic [OVS_W-1:0] OVS_LAST = OVS_W'(OVS_RATIO - 1);

  logic [PRE_W-1:0] act_pre;
  logic [DIV_W-1:0] act_div;
  logic             apply;
  logic             pre_tick;
  logic             unused_word_bits;

  assign unused_word_bits = ^cfg_wdata;

  btg_ctrl #(.PRE_W(PRE_W), .DIV_W(DIV_W)) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .new_pre  (cfg_wdata[PRE_LSB +: PRE_W]),
    .new_div  (cfg_wdata[DIV_LSB +: DIV_W]),
    .bit_tick (bit_tick),
    .act_pre  (act_pre),
    .act_div  (act_div),
    .busy     (busy),
    .apply    (apply)
  );

  // Stage 1: prescaler, free running
  btg_stage #(.W(PRE_W)) pre_i (
    .clk(clk), .rst_n(rst_n), .restart(apply),
    .adv(1'b1), .limit(act_pre), .wrap(pre_tick)
  );

  // Stage 2: baud divisor, yields the sample tick
  btg_stage #(.W(DIV_W)) div_i (
    .clk(clk), .rst_n(rst_n), .restart(apply),
    .adv(pre_tick), .limit(act_div), .wrap(sample_tick)
  );

  // Stage 3: oversampling counter, yields the bit tick
  btg_stage #(.W(OVS_W)) ovs_i (
    .clk(clk), .rst_n(rst_n), .restart(apply),
    .adv(sample_tick), .limit(OVS_LAST), .wrap(bit_tick)
  );
endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk
  import btg_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic cfg_we,
  input logic busy,
  input logic sample_tick,
  input logic bit_tick
);
  logic [OVS_W-1:0] smp_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           smp_seen <= '0;
    else if (bit_tick)    smp_seen <= '0;
    else if (sample_tick) smp_seen <= smp_seen + 1'b1;
  end

  p_bit_on_sample_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> sample_tick);

  p_thirteenth_sample_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> (smp_seen == OVS_W'(OVS_RATIO - 1)));

  p_busy_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !bit_tick) |=> busy);

  p_busy_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bit_tick) |=> busy);

  p_busy_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(bit_tick));

  p_coincide_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && bit_tick) |=> !busy);
endmodule

bind baud_tick_gen baud_tick_gen_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .busy(busy),
  .sample_tick(sample_tick), .bit_tick(bit_tick)
);

// File: tb/baud_tick_gen_tb_top.sv
`timescale 1ns/1ps
module baud_tick_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        busy, sample_tick, bit_tick;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  localparam int NV = 8;
  // configuration word and expected (pre+1)*(div+1) per R1
  localparam logic [31:0] V_WORD [NV] = '{32'h0000_0001, 32'h0001_0000,
    32'h0002_0004, 32'h000F_0003, 32'hFFF0_FC05, 32'h0003_0009,
    32'h0000_03FF, 32'h0000_0000};
  localparam int V_PD [NV] = '{2, 2, 15, 64, 6, 40, 1024, 1};

  always #2.5 clk = ~clk;

  baud_tick_gen dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .busy(busy), .sample_tick(sample_tick), .bit_tick(bit_tick)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic write_word(input logic [31:0] w);
    cfg_we = 1'b1; cfg_wdata = w;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic wait_bit();
    while (!bit_tick) step();
  endtask

  // Called at a bit_tick negedge: checks one full bit window.
  task automatic measure(input int pd, input string req);
    int n = 0, first = 0, smp = 0;
    do begin
      step(); n++;
      if (sample_tick) begin smp++; if (first == 0) first = n; end
    end while (!bit_tick);
    check(first == pd, {req, " sample period"}, first, pd);
    check(smp == 13, {req, " samples per bit"}, smp, 13);
    check(n == 13 * pd, {req, " bit period"}, n, 13 * pd);
  endtask

  task automatic do_reset();
    int k = 0;
    rst_n = 1'b0;
    step(); step();
    rst_n = 1'b1;
    // R4: reset state visible at the release cycle
    check(busy == 1'b0, "R4 busy after reset", busy, 0);
    check(sample_tick == 1'b1, "R4 sample at fastest rate", sample_tick, 1);
    while (!bit_tick) begin step(); k++; end
    check(k == 12, "R4 first bit tick cycle index", k, 12);
  endtask

  // Write then wait for the setting to take over; leaves caller 1 cycle after boundary.
  task automatic load(input logic [31:0] w, input int pd, input string req);
    bit coinc, seen;
    int n;
    coinc = bit_tick;
    write_word(w);
    if (!coinc) check(busy == 1'b1, {req, " R5 busy after write"}, busy, 1);
    seen = coinc;
    while (busy) begin seen = bit_tick; step(); end
    check(seen, {req, " R5 busy cleared at bit boundary"}, seen, 1);
    n = 1;
    while (!sample_tick) begin step(); n++; end
    check(n == pd, {req, " R9 first sample after restart"}, n, pd);
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog all-reqs actual=%0d expected=<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    step();
    do_reset();
    measure(1, "R3 reset rate");

    // table walk: R1 field placement, R2, R3 periods
    for (int i = 0; i < NV; i++) begin
      load(V_WORD[i], V_PD[i], "R1");
      wait_bit();
      measure(V_PD[i], $sformatf("R2/R3 vec%0d", i));
    end

    // R6: mid-bit write leaves current bit at old length (PD 10 -> 130 cycles)
    load(32'h0000_0009, 10, "R6 setup");
    wait_bit();
    begin
      int n = 0;
      repeat (40) begin step(); n++; end
      write_word(32'h0000_0001); n++;
      check(busy == 1'b1, "R5 busy mid bit", busy, 1);
      while (!bit_tick) begin step(); n++; end
      check(n == 130, "R6 old bit length kept", n, 130);
      step();
      check(busy == 1'b0, "R5 busy clears after boundary", busy, 1'b0);
    end
    wait_bit();
    measure(2, "R6 new rate");

    // R8: second write while busy wins
    wait_bit();
    repeat (3) step();
    write_word(32'h0000_0007);
    write_word(32'h0000_0002);
    while (busy) step();
    wait_bit();
    measure(3, "R8 last write");

    // R7: write coinciding with a bit tick
    wait_bit();
    cfg_we = 1'b1; cfg_wdata = 32'h0000_0004;
    step();
    cfg_we = 1'b0;
    check(busy == 1'b0, "R7 busy stays low", busy, 0);
    begin
      int n = 1;
      while (!bit_tick) begin step(); n++; end
      check(n == 65, "R7 applied at that boundary", n, 65);
    end

    // R4: reset in mid-run returns to the defaults
    step();
    do_reset();
    measure(1, "R4 post reset rate");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule